// File: doc/BRIEF.md
# Masked Substitution Round Stage

This block is a single round stage of a Boolean-masked 4-bit substitution. It holds two registers: a data register that always carries the secret value `x` XORed with a mask, and a mask register that carries that mask. A step replaces the masked value `x^m` with `S(x^k)^m'`. Here `S` is a fixed substitution table, `k` is the key nibble and `m'` is a fresh mask supplied from outside. In the same clock edge the mask register moves to `m'`. The unmasked value never lands in a flop.

Two build-time choices shape the stage. In the default structure, one table is indexed by the masked value concatenated with the mask, so its size is `2^(2n)` entries. The table is rebuilt combinationally for the current key. The alternative structure strips the mask, applies the plain table and remasks with `m'`.

Independently of that choice, the mask register can hold an encoded mask `B(m)` instead of the raw mask. `B` is a fixed nibble bijection. The decoder `B^-1` sits in front of every consumer of the mask. A load strobe seeds the stage with an externally masked input and its raw mask. The random source and the rest of the cipher sit outside.

Top module: `masked_sbox_stage`

## Requirements
- R1: A synchronous reset sets both `data_q` and `mask_q` to 0 at the next rising edge.
- R2: With `load` high at a rising edge, `data_q` takes `load_data`, and the mask register takes `load_mask` (stored encoded when squeezing is enabled).
- R3: With `step` high and `load` low at a rising edge, the recovered mask becomes `fresh_mask`. `data_q ^ fresh_mask` equals `S((data_q_old ^ mask_old) ^ key)`, where `mask_old` is the recovered mask before the edge.
- R4: The data and mask registers update on the same edge. After a step, the stored pair always recombines to the new secret value.
- R5: With neither `load` nor `step` high, both registers keep their values.
- R6: When `load` and `step` are both high, the load takes effect and the step is ignored.
- R7: With squeezing enabled, `mask_q` equals `B(m)`; with it disabled, `mask_q` equals `m`. The recovered mask is `B^-1(mask_q)`.
- R8: The table-per-key structure and the recompute structure produce identical `data_q` and `mask_q` sequences for identical inputs.
- R9: The table `S` is the parameter `SBOX_TAB`, with entry `i` at bits `[4i+3:4i]`. The default entries for i=0..15 are C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2. The bijection `B` is `ENC_TAB` with the same packing. Its default entries are 3,8,F,1,A,6,5,B,E,D,4,2,7,0,9,C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Seed the registers from `load_data` / `load_mask` |
| step | input | 1 | Perform one masked substitution |
| load_data | input | 4 | Externally masked input value |
| load_mask | input | 4 | Raw mask belonging to `load_data` |
| key | input | 4 | Key nibble added before substitution |
| fresh_mask | input | 4 | New output mask m' |
| data_q | output | 4 | Masked data register |
| mask_q | output | 4 | Mask register (encoded when squeezing) |

## Verification
The bound checker evaluates every clock edge. It checks the reset clearing, that a load captures the supplied pair, and that a step moves the recovered mask to the fresh one while recombining to the substituted secret. It also checks that an idle cycle holds both registers.

Only the bench scenarios can show the rest. That includes the exact encoded register contents in each mode and load-over-step priority with conflicting inputs. It also includes the equivalence of the two lookup structures: the bench runs two differently configured instances side by side over long random chains.

// File: rtl/masksq_pkg.sv
package masksq_pkg;
  localparam int NB    = 4;
  localparam int NENT  = 1 << NB;
  localparam int TBITS = NB * NENT;

  typedef logic [NB-1:0]    nib_t;
  typedef logic [TBITS-1:0] tab_t;

  function automatic nib_t tab_read(tab_t tab, nib_t idx);
    return tab[idx*NB +: NB];
  endfunction

  function automatic nib_t tab_invert(tab_t tab, nib_t val);
    nib_t res = '0;
    for (int i = 0; i < NENT; i++)
      if (tab[i*NB +: NB] == val) res = nib_t'(i);
    return res;
  endfunction
endpackage

// File: rtl/mask_codec.sv
module mask_codec
  import masksq_pkg::*;
#(
  parameter tab_t ENC_TAB = 64'hC907_24DE_B56A_1F83,
  parameter bit   SQUEEZE = 1'b1
) (
  input  nib_t raw_in,
  input  nib_t stored_in,
  output nib_t stored_out,
  output nib_t raw_out
);
  generate
    if (SQUEEZE) begin : g_sq
      assign stored_out = tab_read(ENC_TAB, raw_in);
      assign raw_out    = tab_invert(ENC_TAB, stored_in);
    end else begin : g_raw
      assign stored_out = raw_in;
      assign raw_out    = stored_in;
    end
  endgenerate
endmodule

// File: rtl/masked_lut.sv
module masked_lut
  import masksq_pkg::*;
#(
  parameter tab_t SBOX_TAB  = 64'h2174_8FE3_DA09_B65C,
  parameter bit   RECOMPUTE = 1'b0
) (
  input  nib_t masked_in,
  input  nib_t mask_in,
  input  nib_t key,
  input  nib_t fresh_mask,
  output nib_t remasked
);
  localparam int ADDR_W = 2 * NB;
  localparam int DEPTH  = 1 << ADDR_W;

  generate
    if (RECOMPUTE) begin : g_recomp
      nib_t plain_idx;
      assign plain_idx = masked_in ^ mask_in ^ key;
      assign remasked  = tab_read(SBOX_TAB, plain_idx) ^ fresh_mask;
    end else begin : g_zoff
      nib_t tbl [DEPTH];
      logic [ADDR_W-1:0] addr;
      for (genvar a = 0; a < DEPTH; a++) begin : g_ent
        localparam logic [ADDR_W-1:0] AV = ADDR_W'(a);
        assign tbl[a] = tab_read(SBOX_TAB, AV[NB-1:0] ^ AV[ADDR_W-1:NB] ^ key);
      end
      assign addr     = {mask_in, masked_in};
      assign remasked = tbl[addr] ^ fresh_mask;
    end
  endgenerate
endmodule

// File: rtl/masked_sbox_stage.sv
module masked_sbox_stage
  import masksq_pkg::*;
#(
  parameter tab_t SBOX_TAB  = 64'h2174_8FE3_DA09_B65C,
  parameter tab_t ENC_TAB   = 64'hC907_24DE_B56A_1F83,
  parameter bit   SQUEEZE   = 1'b1,
  parameter bit   RECOMPUTE = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic        step,
  input  logic [3:0]  load_data,
  input  logic [3:0]  load_mask,
  input  logic [3:0]  key,
  input  logic [3:0]  fresh_mask,
  output logic [3:0]  data_q,
  output logic [3:0]  mask_q
);
  nib_t mask_plain;
  nib_t mask_src;
  nib_t mask_enc_next;
  nib_t lut_out;
  logic do_load;
  logic do_step;

  assign do_load  = load;
  assign do_step  = step & ~load;
  assign mask_src = do_load ? load_mask : fresh_mask;

  mask_codec #(.ENC_TAB(ENC_TAB), .SQUEEZE(SQUEEZE)) u_codec (
    .raw_in    (mask_src),
    .stored_in (mask_q),
    .stored_out(mask_enc_next),
    .raw_out   (mask_plain)
  );

  masked_lut #(.SBOX_TAB(SBOX_TAB), .RECOMPUTE(RECOMPUTE)) u_lut (
    .masked_in (data_q),
    .mask_in   (mask_plain),
    .key       (key),
    .fresh_mask(fresh_mask),
    .remasked  (lut_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      mask_q <= '0;
    end else if (do_load) begin
      data_q <= load_data;
      mask_q <= mask_enc_next;
    end else if (do_step) begin
      data_q <= lut_out;
      mask_q <= mask_enc_next;
    end
  end
endmodule

// File: rtl/masked_sbox_stage_chk.sv
module masked_sbox_stage_chk
  import masksq_pkg::*;
#(
  parameter tab_t SBOX_TAB = 64'h2174_8FE3_DA09_B65C
) (
  input logic       clk,
  input logic       rst,
  input logic       load,
  input logic       step,
  input logic [3:0] load_data,
  input logic [3:0] load_mask,
  input logic [3:0] key,
  input logic [3:0] fresh_mask,
  input logic [3:0] data_q,
  input logic [3:0] mask_q,
  input logic [3:0] mask_plain
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (data_q == 4'h0 && mask_q == 4'h0));

  assert_load_capture_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (data_q == $past(load_data) && mask_plain == $past(load_mask)));

  assert_step_mask_R3: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> mask_plain == $past(fresh_mask));

  assert_step_recombine_R4: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (data_q ^ mask_plain) ==
      tab_read(SBOX_TAB, $past(data_q ^ mask_plain) ^ $past(key)));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> ($stable(data_q) && $stable(mask_q)));
endmodule

bind masked_sbox_stage masked_sbox_stage_chk #(.SBOX_TAB(SBOX_TAB)) u_chk (
  .clk(clk), .rst(rst), .load(load), .step(step),
  .load_data(load_data), .load_mask(load_mask), .key(key),
  .fresh_mask(fresh_mask), .data_q(data_q), .mask_q(mask_q),
  .mask_plain(mask_plain)
);

// File: tb/masked_sbox_stage_tb.sv
module masked_sbox_stage_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0, step = 1'b0;
  logic [3:0] load_data = '0, load_mask = '0, key = '0, fresh_mask = '0;
  logic [3:0] d_a, m_a, d_b, m_b;
  int errors = 0, checks = 0;
  logic [3:0] secret;

  always #10 clk = ~clk;

  masked_sbox_stage u_dut (
    .clk(clk), .rst(rst), .load(load), .step(step), .load_data(load_data),
    .load_mask(load_mask), .key(key), .fresh_mask(fresh_mask),
    .data_q(d_a), .mask_q(m_a));

  masked_sbox_stage #(.SQUEEZE(1'b0), .RECOMPUTE(1'b1)) u_alt (
    .clk(clk), .rst(rst), .load(load), .step(step), .load_data(load_data),
    .load_mask(load_mask), .key(key), .fresh_mask(fresh_mask),
    .data_q(d_b), .mask_q(m_b));

  function automatic logic [3:0] s_ref(logic [3:0] v);
    case (v)
      4'h0: return 4'hC; 4'h1: return 4'h5; 4'h2: return 4'h6; 4'h3: return 4'hB;
      4'h4: return 4'h9; 4'h5: return 4'h0; 4'h6: return 4'hA; 4'h7: return 4'hD;
      4'h8: return 4'h3; 4'h9: return 4'hE; 4'hA: return 4'hF; 4'hB: return 4'h8;
      4'hC: return 4'h4; 4'hD: return 4'h7; 4'hE: return 4'h1; default: return 4'h2;
    endcase
  endfunction

  function automatic logic [3:0] b_ref(logic [3:0] v);
    case (v)
      4'h0: return 4'h3; 4'h1: return 4'h8; 4'h2: return 4'hF; 4'h3: return 4'h1;
      4'h4: return 4'hA; 4'h5: return 4'h6; 4'h6: return 4'h5; 4'h7: return 4'hB;
      4'h8: return 4'hE; 4'h9: return 4'hD; 4'hA: return 4'h4; 4'hB: return 4'h2;
      4'hC: return 4'h7; 4'hD: return 4'h0; 4'hE: return 4'h9; default: return 4'hC;
    endcase
  endfunction

  function automatic logic [3:0] binv_ref(logic [3:0] v);
    for (int i = 0; i < 16; i++)
      if (b_ref(4'(i)) == v) return 4'(i);
    return 4'h0;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycle(input logic ld, input logic st, input logic [3:0] ldd,
                       input logic [3:0] ldm, input logic [3:0] k, input logic [3:0] fm);
    @(negedge clk);
    load = ld; step = st; load_data = ldd; load_mask = ldm; key = k; fresh_mask = fm;
    @(posedge clk);
    #2;
  endtask

  task automatic check_pair(input string tag, input logic [3:0] dexp, input logic [3:0] mraw);
    check(d_a == dexp, {tag, " sq data"}, d_a, dexp);
    check(m_a == b_ref(mraw), {tag, " R7 sq mask"}, m_a, b_ref(mraw));
    check(d_b == dexp, {tag, " R8 alt data"}, d_b, dexp);
    check(m_b == mraw, {tag, " R7 raw mask"}, m_b, mraw);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    logic [3:0] x, m, k, f;
    void'($urandom(32'd1234));
    cycle(1'b0, 1'b0, 4'h0, 4'h0, 4'h0, 4'h0);
    cycle(1'b0, 1'b0, 4'h0, 4'h0, 4'h0, 4'h0);
    // R1: reset clears both registers
    check(d_a == 0 && m_a == 0 && d_b == 0 && m_b == 0, "R1 reset", {d_a, m_a}, 0);
    @(negedge clk); rst = 1'b0;

    // R2: load captures masked data and mask (x=9, m=5)
    cycle(1'b1, 1'b0, 4'h9 ^ 4'h5, 4'h5, 4'h0, 4'h0);
    check_pair("R2 load", 4'h9 ^ 4'h5, 4'h5);
    secret = 4'h9;

    // R3/R4 corner: key 0, fresh mask F
    cycle(1'b0, 1'b1, 4'h0, 4'h0, 4'h0, 4'hF);
    secret = s_ref(secret ^ 4'h0);
    check_pair("R3 step k0", secret ^ 4'hF, 4'hF);

    // R5: idle holds both registers even with other inputs changing
    cycle(1'b0, 1'b0, 4'h3, 4'h7, 4'hA, 4'h2);
    check_pair("R5 hold", secret ^ 4'hF, 4'hF);

    // R6: load and step together, load wins
    cycle(1'b1, 1'b1, 4'hE, 4'h0, 4'h6, 4'hB);
    check_pair("R6 priority", 4'hE, 4'h0);
    secret = 4'hE;

    // R3/R4/R8: random chains; R9 table values via s_ref/b_ref
    for (int i = 0; i < 300; i++) begin
      k = 4'($urandom); f = 4'($urandom);
      if (i % 37 == 0) begin
        x = 4'($urandom); m = 4'($urandom);
        cycle(1'b1, 1'b0, x ^ m, m, k, f);
        secret = x;
        check_pair("R2 reload", x ^ m, m);
      end else begin
        cycle(1'b0, 1'b1, 4'h0, 4'h0, k, f);
        secret = s_ref(secret ^ k);
        check((d_a ^ binv_ref(m_a)) == secret, "R4 recombine sq", d_a ^ binv_ref(m_a), secret);
        check((d_b ^ m_b) == secret, "R4 recombine raw", d_b ^ m_b, secret);
        check_pair("R3 step", secret ^ f, f);
      end
    end

    // R9: every table entry through one step from a zero mask, key zero
    for (int v = 0; v < 16; v++) begin
      cycle(1'b1, 1'b0, 4'(v), 4'h0, 4'h0, 4'h0);
      cycle(1'b0, 1'b1, 4'h0, 4'h0, 4'h0, 4'h0);
      check_pair("R9 entry", s_ref(4'(v)), 4'h0);
    end

    // R1: reset mid-run clears again
    @(negedge clk); rst = 1'b1;
    cycle(1'b0, 1'b1, 4'h0, 4'h0, 4'h5, 4'h5);
    check(d_a == 0 && m_a == 0 && d_b == 0 && m_b == 0, "R1 reset again", {d_a, m_a}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule